// File: doc/BRIEF.md
# Real-Time Counter with Periodic Alarm

This peripheral keeps a free-running 32-bit count of slow clock ticks and raises a periodic alarm that can also serve as a wakeup source. Four single-cycle tick strobes, each marking an edge of a different slow clock, enter the block. A two-bit selector in the control register picks one of them. The selected strobe passes through a chain of two optional prescalers, divide-by-32 and divide-by-512. Either prescaler can be bypassed, so the overall division is 1, 32, 512 or 16384. The resulting prescaled tick advances the counter and drives the periodic-interrupt unit.

Software controls the block through a simple register port. The port gives access to the count, a control register, a status register and a 32-bit interval register. Writing the interval register starts a handover into the tick domain, and that handover takes three ticks of the selected source. While the handover is running, a busy flag is raised and further interval writes are dropped.

When the configured number of prescaled ticks has elapsed, the unit sets a sticky flag and begins counting the next interval. Software clears the flag by writing 1 to it. The interrupt line is asserted only while the flag, the unit enable and the interrupt enable are all set.

Top module: `rtc_counter_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: The control register holds these fields, and all other bits read 0:
  - run enable at bit 31
  - periodic unit enable at bit 15
  - interrupt enable at bit 14
  - source select at bits 13:12
  - divide-by-512 enable at bit 11
  - divide-by-32 enable at bit 10
- R3: The count register (byte offset 0x0) increments by one on each prescaled tick while run enable is 1. It holds its value while run enable is 0. The prescaler state clears while run enable is 0.
- R4: Source select value k makes `src_tick_i[k]` the only strobe that advances the block. Strobes on the other lines have no effect.
- R5: With only divide-by-32 enabled, one prescaled tick occurs for every 32 source ticks.
- R6: With only divide-by-512 enabled, one prescaled tick occurs for every 512 source ticks. With both dividers enabled, one occurs for every 16384 source ticks.
- R7: Source select and the divider enables update only on a control write made while run enable is currently 0. Otherwise those fields keep their old values, while the other control bits still update.
- R8: With the unit enabled and a non-zero interval N in effect, the flag (status bit 13) sets on the Nth prescaled tick after the interval took effect, and counting restarts from zero. An interval of 0 never sets the flag.
- R9: Writing 1 to status bit 13 clears the flag, and writing 0 to it leaves the flag unchanged. When a clear and a new event fall in the same cycle, the flag stays set.
- R10: `irq_o` is high exactly when the flag, the unit enable and the interrupt enable are all 1.
- R11: An accepted interval write sets status bit 17. The bit stays set for three selected source ticks. During that time the interval register (offset 0x10) reads back the previous value, and when the bit clears it reads back the new value.
- R12: An interval write made while status bit 17 is 1 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 4 | One-cycle tick strobes, one per slow clock source |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Periodic interrupt / wakeup request |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a new interval event. To reach it, the stimulus first counts the interval up to one tick short of completion. It then drives the final source strobe and the status write on the same clock edge, and checks that the flag remains set. A second hard case is the combined /16384 setting: the prescaler boundary is checked by counting 16383 strobes with no change to the count, followed by one more strobe that advances it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int SEL_W  = 2;
    localparam int N_SRC  = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] OFS_COUNT = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_IVAL  = 5'h10;

    localparam int B_RUN     = 31;
    localparam int B_UNIT_EN = 15;
    localparam int B_IRQ_EN  = 14;
    localparam int B_SRC_LO  = 12;
    localparam int B_SLOW512 = 11;
    localparam int B_SLOW32  = 10;
    localparam int B_BUSY    = 17;
    localparam int B_FLAG    = 13;

    typedef struct packed {
        logic             run;
        logic             unit_en;
        logic             irq_en;
        logic [SEL_W-1:0] src;
        logic             slow512;
        logic             slow32;
    } ctrl_t;

endpackage

// File: rtl/rtc_prescale_stage.sv
module rtc_prescale_stage #(
    parameter int DIV = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic bypass_i,
    input  logic tick_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && !bypass_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o = bypass_i ? tick_i : (tick_i && (cnt_q == LAST));

endmodule

// File: rtl/rtc_ival_sync.sv
module rtc_ival_sync #(
    parameter int W          = 32,
    parameter int SYNC_TICKS = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         tick_i,
    output logic         busy_o,
    output logic [W-1:0] ival_o,
    output logic         done_o
);
    localparam int SW = $clog2(SYNC_TICKS + 1);
    localparam logic [SW-1:0] LAST = SW'(SYNC_TICKS - 1);

    typedef struct packed {
        logic          busy;
        logic [SW-1:0] cnt;
        logic [W-1:0]  pend;
        logic [W-1:0]  ival;
    } sync_t;

    sync_t s_d, s_q;
    logic  done;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (s_q.busy) begin
            if (tick_i) begin
                if (s_q.cnt == LAST) begin
                    s_d.busy = 1'b0;
                    s_d.cnt  = '0;
                    s_d.ival = s_q.pend;
                    done     = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else if (wr_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.pend = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign ival_o = s_q.ival;
    assign done_o = done;

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         unit_en_i,
    input  logic         tick_i,
    input  logic [W-1:0] ival_i,
    input  logic         restart_i,
    input  logic         clr_i,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] icnt;
        logic         flag;
    } per_t;

    per_t p_d, p_q;
    logic hit;

    always_comb begin
        p_d = p_q;
        hit = 1'b0;
        if (restart_i) begin
            p_d.icnt = '0;
        end else if (unit_en_i && tick_i && (ival_i != '0)) begin
            if (p_q.icnt + 1'b1 == ival_i) begin
                p_d.icnt = '0;
                hit      = 1'b1;
            end else begin
                p_d.icnt = p_q.icnt + 1'b1;
            end
        end
        p_d.flag = hit | (p_q.flag & ~clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) p_q <= '0;
        else         p_q <= p_d;
    end

    assign flag_o = p_q.flag;

endmodule

// File: rtl/rtc_counter_top.sv
module rtc_counter_top
    import rtc_pkg::*;
#(
    parameter int DIV_LO     = 32,
    parameter int DIV_HI     = 512,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  src_tick_i,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam int N_STAGE = 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] count;
    } top_t;

    top_t t_d, t_q;

    logic wr_ctrl, wr_stat, wr_ival;
    logic sel_tick;
    logic [N_STAGE:0] chain;
    logic busy, sync_done, flag;
    logic [DATA_W-1:0] ival_cur;

    assign wr_ctrl  = bus_req_i && bus_we_i && (bus_addr_i == OFS_CTRL);
    assign wr_stat  = bus_req_i && bus_we_i && (bus_addr_i == OFS_STAT);
    assign wr_ival  = bus_req_i && bus_we_i && (bus_addr_i == OFS_IVAL);
    assign sel_tick = src_tick_i[t_q.ctrl.src];
    assign chain[0] = sel_tick && t_q.ctrl.run;

    for (genvar gi = 0; gi < N_STAGE; gi++) begin : g_stage
        localparam int SDIV = (gi == 0) ? DIV_LO : DIV_HI;
        logic bypass;
        assign bypass = (gi == 0) ? !t_q.ctrl.slow32 : !t_q.ctrl.slow512;
        rtc_prescale_stage #(.DIV(SDIV)) u_stage (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (!t_q.ctrl.run),
            .bypass_i(bypass),
            .tick_i  (chain[gi]),
            .tick_o  (chain[gi+1])
        );
    end

    rtc_ival_sync #(.W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr_ival),
        .wdata_i(bus_wdata_i),
        .tick_i (sel_tick),
        .busy_o (busy),
        .ival_o (ival_cur),
        .done_o (sync_done)
    );

    rtc_periodic #(.W(DATA_W)) u_periodic (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .unit_en_i(t_q.ctrl.unit_en),
        .tick_i   (chain[N_STAGE]),
        .ival_i   (ival_cur),
        .restart_i(sync_done),
        .clr_i    (wr_stat && bus_wdata_i[B_FLAG]),
        .flag_o   (flag)
    );

    always_comb begin
        t_d = t_q;
        if (chain[N_STAGE]) t_d.count = t_q.count + 1'b1;
        if (wr_ctrl) begin
            t_d.ctrl.run     = bus_wdata_i[B_RUN];
            t_d.ctrl.unit_en = bus_wdata_i[B_UNIT_EN];
            t_d.ctrl.irq_en  = bus_wdata_i[B_IRQ_EN];
            if (!t_q.ctrl.run) begin
                t_d.ctrl.src     = bus_wdata_i[B_SRC_LO +: SEL_W];
                t_d.ctrl.slow512 = bus_wdata_i[B_SLOW512];
                t_d.ctrl.slow32  = bus_wdata_i[B_SLOW32];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            OFS_COUNT: bus_rdata_o = t_q.count;
            OFS_CTRL: begin
                bus_rdata_o[B_RUN]                = t_q.ctrl.run;
                bus_rdata_o[B_UNIT_EN]            = t_q.ctrl.unit_en;
                bus_rdata_o[B_IRQ_EN]             = t_q.ctrl.irq_en;
                bus_rdata_o[B_SRC_LO +: SEL_W]    = t_q.ctrl.src;
                bus_rdata_o[B_SLOW512]            = t_q.ctrl.slow512;
                bus_rdata_o[B_SLOW32]             = t_q.ctrl.slow32;
            end
            OFS_STAT: begin
                bus_rdata_o[B_BUSY] = busy;
                bus_rdata_o[B_FLAG] = flag;
            end
            OFS_IVAL: bus_rdata_o = ival_cur;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign irq_o = flag && t_q.ctrl.unit_en && t_q.ctrl.irq_en;

endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        flag,
    input logic        busy,
    input logic        wr_stat,
    input logic        wr_ival,
    input logic        clr_bit,
    input logic [31:0] ival_cur,
    input logic [31:0] count,
    input logic [4:0]  cfg,
    input logic        run,
    input logic        irq_o
);
    assert_flag_clear_only_by_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(flag) |-> $past(wr_stat && clr_bit));

    assert_ival_changes_at_sync_end_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ival_cur) |-> $fell(busy));

    assert_busy_rises_on_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy) |-> $past(wr_ival));

    assert_cfg_frozen_while_running_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |=> $stable(cfg));

    assert_count_holds_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> $stable(count));

    assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag);
endmodule

bind rtc_counter_top rtc_counter_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flag    (flag),
    .busy    (busy),
    .wr_stat (wr_stat),
    .wr_ival (wr_ival),
    .clr_bit (bus_wdata_i[13]),
    .ival_cur(ival_cur),
    .count   (t_q.count),
    .cfg     ({t_q.ctrl.src, t_q.ctrl.slow512, t_q.ctrl.slow32}),
    .run     (t_q.ctrl.run),
    .irq_o   (irq_o)
);

// File: tb/rtc_counter_top_bench.sv
module rtc_counter_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        irq;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rtc_counter_top u_rtc_counter_top (
        .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); req = 0; we = 0; wdata = '0;
    endtask

    task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); addr = a; #2;
        check(tag, rdata, exp);
    endtask

    task automatic irq_check(input string tag, input logic exp);
        @(negedge clk); #2;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic pulse(input int n, input int line);
        if (n > 0) begin
            @(negedge clk); src_tick = 4'b1 << line;
            repeat (n) @(negedge clk);
            src_tick = '0;
        end
    endtask

    task automatic t_reset;
        rd_check("R1 count", 5'h00, 0);
        rd_check("R1 ctrl", 5'h04, 0);
        rd_check("R1 stat", 5'h08, 0);
        rd_check("R1 ival", 5'h10, 0);
        irq_check("R1 irq", 0);
    endtask

    task automatic t_ctrl_layout;
        wr(5'h04, 32'hFFFF_FFFF);
        rd_check("R2 ctrl fields", 5'h04, 32'h8000_FC00);
        wr(5'h04, 32'h0);
        rd_check("R7 cfg kept on stop write", 5'h04, 32'h0000_3C00);
        wr(5'h04, 32'h0);
        rd_check("R2 ctrl cleared", 5'h04, 32'h0);
    endtask

    task automatic t_count_and_select;
        wr(5'h04, 32'h8000_0000);
        pulse(10, 0);
        rd_check("R3 count runs", 5'h00, 10);
        pulse(5, 1);
        rd_check("R4 other line ignored", 5'h00, 10);
        wr(5'h04, 32'h0);
        pulse(4, 0);
        rd_check("R3 count holds stopped", 5'h00, 10);
        wr(5'h04, 32'h8000_2000);
        pulse(7, 2);
        rd_check("R4 line2 selected", 5'h00, 17);
        pulse(3, 0);
        rd_check("R4 line0 ignored", 5'h00, 17);
        wr(5'h04, 32'h8000_3C00);
        rd_check("R7 cfg ignored running", 5'h04, 32'h8000_2000);
        pulse(2, 2);
        rd_check("R7 no divider took effect", 5'h00, 19);
    endtask

    task automatic t_dividers;
        wr(5'h04, 32'h0);
        wr(5'h04, 32'h8000_0400);
        pulse(31, 0);
        rd_check("R5 div32 before edge", 5'h00, 19);
        pulse(1, 0);
        rd_check("R5 div32 edge", 5'h00, 20);
        pulse(64, 0);
        rd_check("R5 div32 two more", 5'h00, 22);
        wr(5'h04, 32'h0);
        wr(5'h04, 32'h8000_0800);
        pulse(511, 0);
        rd_check("R6 div512 before edge", 5'h00, 22);
        pulse(1, 0);
        rd_check("R6 div512 edge", 5'h00, 23);
        wr(5'h04, 32'h0);
        wr(5'h04, 32'h8000_0C00);
        pulse(16383, 0);
        rd_check("R6 div16384 before edge", 5'h00, 23);
        pulse(1, 0);
        rd_check("R6 div16384 edge", 5'h00, 24);
    endtask

    task automatic t_sync;
        wr(5'h04, 32'h0);
        wr(5'h04, 32'h8000_C000);
        wr(5'h10, 5);
        rd_check("R11 busy set", 5'h08, 32'h0002_0000);
        rd_check("R11 old value during sync", 5'h10, 0);
        wr(5'h10, 9);
        pulse(2, 0);
        rd_check("R11 still busy", 5'h08, 32'h0002_0000);
        pulse(1, 0);
        rd_check("R11 busy cleared", 5'h08, 0);
        rd_check("R12 write during busy dropped", 5'h10, 5);
    endtask

    task automatic t_periodic;
        pulse(4, 0);
        rd_check("R8 no flag early", 5'h08, 0);
        pulse(1, 0);
        rd_check("R8 flag at interval", 5'h08, 32'h0000_2000);
        irq_check("R10 irq high", 1);
        wr(5'h08, 32'h0);
        rd_check("R9 write 0 keeps flag", 5'h08, 32'h0000_2000);
        wr(5'h08, 32'h0000_2000);
        rd_check("R9 w1c clears", 5'h08, 0);
        irq_check("R10 irq low after clear", 0);
        pulse(5, 0);
        rd_check("R8 restarted interval", 5'h08, 32'h0000_2000);
        wr(5'h08, 32'h0000_2000);
        pulse(4, 0);
        @(negedge clk);
        src_tick = 4'b0001; req = 1; we = 1; addr = 5'h08; wdata = 32'h0000_2000;
        @(negedge clk);
        src_tick = '0; req = 0; we = 0; wdata = '0;
        rd_check("R9 set wins over clear", 5'h08, 32'h0000_2000);
        wr(5'h08, 32'h0000_2000);
    endtask

    task automatic t_irq_gate;
        wr(5'h04, 32'h8000_8000);
        pulse(5, 0);
        rd_check("R10 flag set ie off", 5'h08, 32'h0000_2000);
        irq_check("R10 irq off without ie", 0);
        wr(5'h04, 32'h8000_C000);
        irq_check("R10 irq on with ie", 1);
        wr(5'h04, 32'h8000_4000);
        irq_check("R10 irq off without unit", 0);
        wr(5'h08, 32'h0000_2000);
        wr(5'h04, 32'h8000_C000);
    endtask

    task automatic t_zero_interval;
        wr(5'h10, 0);
        pulse(3, 0);
        rd_check("R11 zero loaded", 5'h10, 0);
        pulse(40, 0);
        rd_check("R8 zero interval no event", 5'h08, 0);
        irq_check("R8 zero interval irq", 0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_layout();
        t_count_and_select();
        t_dividers();
        t_sync();
        t_periodic();
        t_irq_gate();
        t_zero_interval();
        finish_run();
    end
endmodule